// File: doc/BRIEF.md
# Storage Fault Classifier and Interrupt Router

This block sits behind a hashed page-table translation unit. When a translation attempt fails, the unit pulses a fault strobe and supplies the access kind, four failure flags and the faulting effective address. The block sorts the failure into an instruction-side or a data-side storage interrupt. It builds the error code or syndrome word that goes with it. It then decides whether the guest supervisor or the hypervisor takes the interrupt.

Routing depends on two virtualization-mode control bits. Which of the two applies is set by the relocation state of the faulting access. Fetches look at instruction relocation and data accesses look at data relocation. A data fault writes its address and syndrome into one of two register banks, one for each handler. The results are registered on the strobe cycle and held until the next strobe. A single-cycle valid pulse marks each new interrupt.

Top module: `fault_router_top`

## Requirements
- R1: After synchronous reset, `irq_vld`, `exc_code`, `err_code` and the address and status registers of both banks are all zero.
- R2: The routing bit is `vm_reloc` when the relevant relocation bit is 1 and `vm_real` when it is 0. The relevant bit is `inst_reloc` for a fetch (`acc_type`=2) and `data_reloc` for a load (`acc_type`=0) or a store (`acc_type`=1).
- R3: A fault goes to the hypervisor variant when the routing bit is 1 and `hyp_state` is 0, and to the ordinary variant otherwise. `exc_code` is one-hot: bit0 = ordinary instruction, bit1 = hypervisor instruction, bit2 = ordinary data, bit3 = hypervisor data.
- R4: A fetch with `seg_noexec` set raises an instruction interrupt with error code 0x10000000. This outranks a page-table miss and any protection denial.
- R5: On a page-table miss, a load produces syndrome 0x40000000, a store produces 0x42000000 and a fetch produces error code 0x40000000. A miss outranks protection denials.
- R6: On a data protection fault, the syndrome is the OR of 0x08000000 (page-protection denial) and 0x00200000 (key-mask denial). A fetch protection fault from either flag gives error code 0x08000000.
- R7: A data interrupt drives `err_code` to zero. It loads `fault_ea` and the syndrome into the hypervisor bank for a hypervisor data interrupt, or into the supervisor bank otherwise, and leaves the other bank unchanged. An instruction interrupt changes neither bank.
- R8: Results appear on the clock edge that samples `flt_vld`. `irq_vld` is high for that one cycle only. `exc_code`, `err_code` and both banks hold their values until the next strobe.
- R9: A strobe with `acc_type`=3, or with no flag that applies to the access, gives no interrupt: `irq_vld`=0, `exc_code`=0 and `err_code`=0, and both banks are unchanged. `seg_noexec` applies only to fetches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flt_vld | input | 1 | Translation fault strobe |
| acc_type | input | 2 | 0 load, 1 store, 2 fetch, 3 none |
| seg_noexec | input | 1 | Segment forbids execution |
| pte_miss | input | 1 | No matching page-table entry |
| prot_deny | input | 1 | Page-protection denial |
| key_deny | input | 1 | Key-mask denial |
| fault_ea | input | AW | Faulting effective address |
| inst_reloc | input | 1 | Instruction relocation enabled |
| data_reloc | input | 1 | Data relocation enabled |
| hyp_state | input | 1 | Processor is in hypervisor state |
| vm_real | input | 1 | Virtualization-mode bit used when relocation is off |
| vm_reloc | input | 1 | Virtualization-mode bit used when relocation is on |
| irq_vld | output | 1 | One-cycle new-interrupt pulse |
| exc_code | output | 4 | One-hot interrupt kind |
| err_code | output | 32 | Instruction-side error code, zero for data |
| sup_addr | output | AW | Supervisor data fault address |
| sup_stat | output | 32 | Supervisor data fault syndrome |
| hyp_addr | output | AW | Hypervisor data fault address |
| hyp_stat | output | 32 | Hypervisor data fault syndrome |

## Verification
The bench sets relocation and the two mode bits so that only the correct choice of bit gives the expected route. A design that always reads one mode bit, or that uses data relocation for fetches, sends an interrupt to the wrong handler. The bench raises several flags at once, so a wrong priority between no-execute, miss and protection produces the wrong code. It also checks store misses and mixed protection denials, where a design that drops the store bit or the key bit produces the wrong syndrome. After each data fault the bench checks the bank that should not change, since a design that writes both banks or that writes a bank on an instruction fault corrupts state held from an earlier fault. It also sends strobes with no applicable flag and checks that no interrupt is raised.

// File: rtl/fault_route_pkg.sv
package fault_route_pkg;
   localparam logic [1:0] ACC_LOAD  = 2'd0;
   localparam logic [1:0] ACC_STORE = 2'd1;
   localparam logic [1:0] ACC_FETCH = 2'd2;
   localparam logic [1:0] ACC_NONE  = 2'd3;

   localparam int EXC_W     = 4;
   localparam int EXC_INST  = 0;
   localparam int EXC_HINST = 1;
   localparam int EXC_DATA  = 2;
   localparam int EXC_HDATA = 3;

   localparam int CODE_W = 32;
   localparam logic [CODE_W-1:0] CODE_SEGNX    = 32'h1000_0000;
   localparam logic [CODE_W-1:0] CODE_MISS     = 32'h4000_0000;
   localparam logic [CODE_W-1:0] CODE_STOREBIT = 32'h0200_0000;
   localparam logic [CODE_W-1:0] CODE_PROT     = 32'h0800_0000;
   localparam logic [CODE_W-1:0] CODE_KEY      = 32'h0020_0000;
endpackage

// File: rtl/fault_classify.sv
module fault_classify
   import fault_route_pkg::*;
(
   input  logic [1:0]        acc_type,
   input  logic              seg_noexec,
   input  logic              pte_miss,
   input  logic              prot_deny,
   input  logic              key_deny,
   output logic              hit,
   output logic              is_fetch,
   output logic [CODE_W-1:0] code
);
   logic is_data;

   always_comb begin
      is_fetch = (acc_type == ACC_FETCH);
      is_data  = (acc_type == ACC_LOAD) || (acc_type == ACC_STORE);
      hit      = 1'b0;
      code     = '0;
      if (is_fetch) begin
         if (seg_noexec) begin
            hit  = 1'b1;
            code = CODE_SEGNX;
         end else if (pte_miss) begin
            hit  = 1'b1;
            code = CODE_MISS;
         end else if (prot_deny || key_deny) begin
            hit  = 1'b1;
            code = CODE_PROT;
         end
      end else if (is_data) begin
         if (pte_miss) begin
            hit  = 1'b1;
            code = CODE_MISS | ((acc_type == ACC_STORE) ? CODE_STOREBIT : '0);
         end else if (prot_deny || key_deny) begin
            hit  = 1'b1;
            code = (prot_deny ? CODE_PROT : '0) | (key_deny ? CODE_KEY : '0);
         end
      end
   end
endmodule

// File: rtl/fault_route.sv
module fault_route #(
   parameter bit HYP_ROUTE = 1'b1
) (
   input  logic is_fetch,
   input  logic inst_reloc,
   input  logic data_reloc,
   input  logic hyp_state,
   input  logic vm_real,
   input  logic vm_reloc,
   output logic to_hyp
);
   logic reloc_on;
   logic mode_bit;

   assign reloc_on = is_fetch ? inst_reloc : data_reloc;
   assign mode_bit = reloc_on ? vm_reloc : vm_real;

   generate
      if (HYP_ROUTE) begin : g_hyp
         assign to_hyp = mode_bit & ~hyp_state;
      end else begin : g_flat
         logic unused_sel;
         assign unused_sel = mode_bit ^ hyp_state;
         assign to_hyp = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/fault_bank.sv
module fault_bank #(
   parameter int AW = 64,
   parameter int SW = 32
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          we,
   input  logic [AW-1:0] addr_in,
   input  logic [SW-1:0] stat_in,
   output logic [AW-1:0] addr_q,
   output logic [SW-1:0] stat_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q <= '0;
         stat_q <= '0;
      end else if (we) begin
         addr_q <= addr_in;
         stat_q <= stat_in;
      end
   end
endmodule

// File: rtl/fault_router_top.sv
module fault_router_top
   import fault_route_pkg::*;
#(
   parameter int AW        = 64,
   parameter bit HYP_ROUTE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              flt_vld,
   input  logic [1:0]        acc_type,
   input  logic              seg_noexec,
   input  logic              pte_miss,
   input  logic              prot_deny,
   input  logic              key_deny,
   input  logic [AW-1:0]     fault_ea,
   input  logic              inst_reloc,
   input  logic              data_reloc,
   input  logic              hyp_state,
   input  logic              vm_real,
   input  logic              vm_reloc,
   output logic              irq_vld,
   output logic [EXC_W-1:0]  exc_code,
   output logic [CODE_W-1:0] err_code,
   output logic [AW-1:0]     sup_addr,
   output logic [CODE_W-1:0] sup_stat,
   output logic [AW-1:0]     hyp_addr,
   output logic [CODE_W-1:0] hyp_stat
);
   localparam int NBANK = 2;

   generate
      if (AW < 32) begin : g_aw_chk
         $error("fault_router_top: AW must be at least 32");
      end
   endgenerate

   logic              hit;
   logic              is_fetch;
   logic [CODE_W-1:0] code;
   logic              to_hyp;
   logic [EXC_W-1:0]  exc_d;
   logic [CODE_W-1:0] err_d;
   logic [AW-1:0]     bank_addr [NBANK];
   logic [CODE_W-1:0] bank_stat [NBANK];

   fault_classify u_cls (
      .acc_type  (acc_type),
      .seg_noexec(seg_noexec),
      .pte_miss  (pte_miss),
      .prot_deny (prot_deny),
      .key_deny  (key_deny),
      .hit       (hit),
      .is_fetch  (is_fetch),
      .code      (code)
   );

   fault_route #(.HYP_ROUTE(HYP_ROUTE)) u_rte (
      .is_fetch  (is_fetch),
      .inst_reloc(inst_reloc),
      .data_reloc(data_reloc),
      .hyp_state (hyp_state),
      .vm_real   (vm_real),
      .vm_reloc  (vm_reloc),
      .to_hyp    (to_hyp)
   );

   always_comb begin
      exc_d = '0;
      err_d = '0;
      if (hit) begin
         if (is_fetch) begin
            exc_d[to_hyp ? EXC_HINST : EXC_INST] = 1'b1;
            err_d = code;
         end else begin
            exc_d[to_hyp ? EXC_HDATA : EXC_DATA] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         irq_vld  <= 1'b0;
         exc_code <= '0;
         err_code <= '0;
      end else begin
         irq_vld <= flt_vld & hit;
         if (flt_vld) begin
            exc_code <= exc_d;
            err_code <= err_d;
         end
      end
   end

   generate
      for (genvar b = 0; b < NBANK; b++) begin : g_bank
         logic bank_we;
         assign bank_we = flt_vld & hit & ~is_fetch & (to_hyp == (b == 1));
         fault_bank #(.AW(AW), .SW(CODE_W)) u_bank (
            .clk    (clk),
            .rst    (rst),
            .we     (bank_we),
            .addr_in(fault_ea),
            .stat_in(code),
            .addr_q (bank_addr[b]),
            .stat_q (bank_stat[b])
         );
      end
   endgenerate

   assign sup_addr = bank_addr[0];
   assign sup_stat = bank_stat[0];
   assign hyp_addr = bank_addr[1];
   assign hyp_stat = bank_stat[1];
endmodule

// File: rtl/fault_router_chk.sv
module fault_router_chk #(
   parameter int AW = 64
) (
   input logic          clk,
   input logic          rst,
   input logic          flt_vld,
   input logic [1:0]    acc_type,
   input logic          hyp_state,
   input logic [AW-1:0] fault_ea,
   input logic          irq_vld,
   input logic [3:0]    exc_code,
   input logic [31:0]   err_code,
   input logic [AW-1:0] sup_addr,
   input logic [31:0]   sup_stat,
   input logic [AW-1:0] hyp_addr,
   input logic [31:0]   hyp_stat
);
   AST_VLD_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst) irq_vld |-> $past(flt_vld)); // R8
   AST_CODE_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(exc_code)); // R3
   AST_VLD_WITH_CODE: assert property (@(posedge clk) disable iff (rst) flt_vld |=> (irq_vld == (exc_code != 4'd0))); // R8
   AST_DATA_ERR_ZERO: assert property (@(posedge clk) disable iff (rst) (exc_code[2] || exc_code[3]) |-> (err_code == 32'd0)); // R7
   AST_HV_STAYS_ORD: assert property (@(posedge clk) disable iff (rst) (flt_vld && hyp_state) |=> (!exc_code[1] && !exc_code[3])); // R3
   AST_NONE_NO_IRQ: assert property (@(posedge clk) disable iff (rst) (flt_vld && acc_type == 2'd3) |=> !irq_vld); // R9
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !flt_vld |=> ($stable(exc_code) && $stable(err_code) && $stable(sup_addr) && $stable(sup_stat) && $stable(hyp_addr) && $stable(hyp_stat))); // R8
   AST_HDATA_BANK: assert property (@(posedge clk) disable iff (rst) (irq_vld && exc_code[3]) |-> (hyp_addr == $past(fault_ea) && $stable(sup_addr) && $stable(sup_stat))); // R7
endmodule

bind fault_router_top fault_router_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_fault_router_top.sv
module sim_fault_router_top;
   logic        clk = 1'b0;
   logic        rst;
   logic        flt_vld;
   logic [1:0]  acc_type;
   logic        seg_noexec, pte_miss, prot_deny, key_deny;
   logic [63:0] fault_ea;
   logic        inst_reloc, data_reloc, hyp_state, vm_real, vm_reloc;
   logic        irq_vld;
   logic [3:0]  exc_code;
   logic [31:0] err_code, sup_stat, hyp_stat;
   logic [63:0] sup_addr, hyp_addr;

   int total = 0;
   int bad = 0;
   logic [63:0] e_sa, e_ha;
   logic [31:0] e_ss, e_hs;

   always #4 clk = ~clk;

   fault_router_top u0 (.*);

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic chk_banks(input string req);
      chk(req, "sup_addr", sup_addr, e_sa);
      chk(req, "sup_stat", {32'd0, sup_stat}, {32'd0, e_ss});
      chk(req, "hyp_addr", hyp_addr, e_ha);
      chk(req, "hyp_stat", {32'd0, hyp_stat}, {32'd0, e_hs});
   endtask

   task automatic fire(input logic [1:0] acc, input logic nx, input logic ms, input logic pp, input logic ky,
                       input logic [63:0] ea, input logic ir, input logic dr, input logic hv,
                       input logic v0, input logic v1);
      @(negedge clk);
      acc_type = acc; seg_noexec = nx; pte_miss = ms; prot_deny = pp; key_deny = ky;
      fault_ea = ea; inst_reloc = ir; data_reloc = dr; hyp_state = hv; vm_real = v0; vm_reloc = v1;
      flt_vld = 1'b1;
      @(negedge clk);
      flt_vld = 1'b0;
      acc_type = 2'd3; seg_noexec = 0; pte_miss = 0; prot_deny = 0; key_deny = 0;
   endtask

   task automatic chk_out(input string req, input logic v, input logic [3:0] c, input logic [31:0] e);
      chk(req, "irq_vld", {63'd0, irq_vld}, {63'd0, v});
      chk(req, "exc_code", {60'd0, exc_code}, {60'd0, c});
      chk(req, "err_code", {32'd0, err_code}, {32'd0, e});
   endtask

   task automatic t_reset;
      e_sa = 0; e_ss = 0; e_ha = 0; e_hs = 0;
      chk_out("R1", 1'b0, 4'd0, 32'd0);
      chk_banks("R1");
   endtask

   task automatic t_noexec;
      // R4: no-exec outranks miss and protection; instruction fault leaves banks (R7)
      fire(2'd2, 1, 1, 1, 1, 64'h1000, 1, 0, 0, 0, 0);
      chk_out("R4", 1'b1, 4'b0001, 32'h1000_0000);
      chk_banks("R7");
   endtask

   task automatic t_miss;
      fire(2'd0, 0, 1, 1, 1, 64'hAAAA_0000_0000_1230, 0, 1, 0, 1, 0);
      e_sa = 64'hAAAA_0000_0000_1230; e_ss = 32'h4000_0000;
      chk_out("R5", 1'b1, 4'b0100, 32'd0);
      chk_banks("R5");
      fire(2'd1, 0, 1, 1, 0, 64'h0000_0000_BEEF_0008, 0, 1, 0, 1, 0);
      e_sa = 64'h0000_0000_BEEF_0008; e_ss = 32'h4200_0000;
      chk_out("R5", 1'b1, 4'b0100, 32'd0);
      chk_banks("R5");
      fire(2'd2, 0, 1, 1, 1, 64'h2000, 1, 0, 0, 0, 0);
      chk_out("R5", 1'b1, 4'b0001, 32'h4000_0000);
      chk_banks("R5");
   endtask

   task automatic t_prot;
      fire(2'd0, 1, 0, 1, 1, 64'h3000, 0, 1, 0, 1, 0);
      e_sa = 64'h3000; e_ss = 32'h0820_0000;
      chk_out("R6", 1'b1, 4'b0100, 32'd0);
      chk_banks("R6");
      fire(2'd1, 0, 0, 0, 1, 64'h3008, 0, 1, 0, 1, 0);
      e_sa = 64'h3008; e_ss = 32'h0020_0000;
      chk_out("R6", 1'b1, 4'b0100, 32'd0);
      chk_banks("R6");
      fire(2'd2, 0, 0, 0, 1, 64'h3010, 0, 0, 0, 0, 0);
      chk_out("R6", 1'b1, 4'b0001, 32'h0800_0000);
      chk_banks("R6");
   endtask

   task automatic t_route;
      // R2: data reloc off selects vm_real (set) -> hypervisor data
      fire(2'd0, 0, 1, 0, 0, 64'h5555_0000, 1, 0, 0, 1, 0);
      e_ha = 64'h5555_0000; e_hs = 32'h4000_0000;
      chk_out("R2", 1'b1, 4'b1000, 32'd0);
      chk_banks("R7");
      // R2: data reloc on selects vm_reloc (clear) -> ordinary
      fire(2'd1, 0, 0, 1, 0, 64'h6666_0000, 0, 1, 0, 1, 0);
      e_sa = 64'h6666_0000; e_ss = 32'h0800_0000;
      chk_out("R2", 1'b1, 4'b0100, 32'd0);
      chk_banks("R7");
      // R2: fetch uses inst_reloc (on) -> vm_reloc set -> hypervisor instruction
      fire(2'd2, 0, 1, 0, 0, 64'h7000, 1, 0, 0, 0, 1);
      chk_out("R2", 1'b1, 4'b0010, 32'h4000_0000);
      // R2: fetch with inst_reloc off uses vm_real, data_reloc ignored
      fire(2'd2, 0, 1, 0, 0, 64'h7008, 0, 1, 0, 1, 0);
      chk_out("R2", 1'b1, 4'b0010, 32'h4000_0000);
      // R3: hypervisor state keeps ordinary routing
      fire(2'd2, 0, 1, 0, 0, 64'h7010, 1, 1, 1, 1, 1);
      chk_out("R3", 1'b1, 4'b0001, 32'h4000_0000);
      fire(2'd0, 0, 1, 0, 0, 64'h7018, 1, 1, 1, 1, 1);
      e_sa = 64'h7018; e_ss = 32'h4000_0000;
      chk_out("R3", 1'b1, 4'b0100, 32'd0);
      chk_banks("R3");
      fire(2'd1, 0, 0, 1, 1, 64'h7020, 1, 1, 0, 0, 1);
      e_ha = 64'h7020; e_hs = 32'h0820_0000;
      chk_out("R3", 1'b1, 4'b1000, 32'd0);
      chk_banks("R7");
   endtask

   task automatic t_nofault;
      fire(2'd3, 1, 1, 1, 1, 64'h9999, 1, 1, 0, 1, 1);
      chk_out("R9", 1'b0, 4'd0, 32'd0);
      chk_banks("R9");
      fire(2'd0, 1, 0, 0, 0, 64'h9998, 1, 1, 0, 1, 1);
      chk_out("R9", 1'b0, 4'd0, 32'd0);
      chk_banks("R9");
   endtask

   task automatic t_hold;
      fire(2'd2, 1, 0, 0, 0, 64'hA000, 1, 1, 0, 0, 1);
      chk_out("R8", 1'b1, 4'b0010, 32'h1000_0000);
      fault_ea = 64'hFFFF; vm_reloc = 0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk_out("R8", 1'b0, 4'b0010, 32'h1000_0000);
      end
      chk_banks("R8");
   endtask

   initial begin
      #400000;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst = 1'b1; flt_vld = 0; acc_type = 2'd3; seg_noexec = 0; pte_miss = 0;
      prot_deny = 0; key_deny = 0; fault_ea = '0; inst_reloc = 0; data_reloc = 0;
      hyp_state = 0; vm_real = 0; vm_reloc = 0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_noexec();
      t_miss();
      t_prot();
      t_route();
      t_nofault();
      t_hold();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule